// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps the fetch status of a single hardware thread. It is a registered state machine that takes the stall and squash traffic sent back from the later pipeline stages, together with the events from the instruction-cache request path, and settles each cycle into one status. It also holds a stall flag for each downstream stage. When a squash is accepted it loads a new fetch PC and the PC of the following instruction, and it reports whether the thread is keeping the fetch stage busy.

The incoming sources are ranked by strict precedence. A commit squash wins over everything else. The reorder-buffer-still-squashing flag comes next, then a decode squash, then a stall, and last the normal request-path progress. A stall never takes a thread out of the wait for an outstanding cache miss. A cache response that does not belong to the miss being waited on is dropped and counted.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset, status_o is RUN (0), pc_load_o is 0, pc_o is 0, npc_o is INST_BYTES and stray_cnt_o is 0.
- R2: Stage n has its own stall flag. A pulse on blk_i[n] sets the flag and a pulse on unblk_i[n] clears it (stage 0 decode, 1 rename, 2 execute, 3 commit). An unblock pulse for a flag that is clear, or one given together with a block pulse for the same stage, is a protocol error. While any flag is set, the status becomes BLOCKED (2) one edge later. When the last flag clears with no other event present, the status returns to RUN.
- R3: While ctx_switch_i is high the thread counts as stalled and goes to BLOCKED like any other stall.
- R4: cmt_squash_i has top priority. On the next edge the status is SQUASHING (1), pc_load_o is 1 for one cycle, and pc_o equals cmt_target_i, whatever state was current and whatever other inputs were present. Any miss or retry still waiting is abandoned.
- R5: While rob_squashing_i is high and no commit squash is present, the status is SQUASHING on the next edge.
- R6: dec_squash_i is accepted only when the status is not SQUASHING. When accepted, it acts like R4 with dec_target_i. When it is ignored, pc_o is left unchanged and pc_load_o stays 0.
- R7: A stall in WAIT_RESP (3) leaves the status in WAIT_RESP.
- R8: BLOCKED and SQUASHING return to RUN after one cycle with no squash and no stall.
- R9: In WAIT_RESP, a response with resp_valid_i and resp_match_i both high moves the status to ACCESS_DONE (5), or to BLOCKED if the thread is stalled. ACCESS_DONE moves to RUN on the next edge.
- R10: Any other response is discarded and leaves the status unaffected. This includes a response that is not matching, one that arrives outside WAIT_RESP, or one that arrives in a squash cycle. stray_cnt_o increments for each such response and saturates at its maximum.
- R11: In RUN, send_fail_i moves to WAIT_RETRY (4) and send_ok_i moves to WAIT_RESP. In WAIT_RETRY, retry_ok_i moves to WAIT_RESP.
- R12: In RUN, fault_i moves to TRAP (6) and quiesce_i moves to QUIESCE (7), with fault ranked first. Both states hold until a squash or a stall arrives.
- R13: stage_active_o is high exactly when thread_active_i is high and the status is RUN, SQUASHING or ACCESS_DONE.
- R14: Whenever a squash target is loaded, npc_o equals pc_o + INST_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thread_active_i | input | 1 | Thread is enabled |
| blk_i | input | N_STAGES | Per-stage block pulses |
| unblk_i | input | N_STAGES | Per-stage unblock pulses |
| ctx_switch_i | input | 1 | Context switch in progress |
| cmt_squash_i | input | 1 | Squash from commit |
| cmt_target_i | input | AW | Commit squash target PC |
| rob_squashing_i | input | 1 | Reorder buffer still squashing |
| dec_squash_i | input | 1 | Squash from decode |
| dec_target_i | input | AW | Decode squash target PC |
| resp_valid_i | input | 1 | Cache response arrives |
| resp_match_i | input | 1 | Response matches outstanding request |
| send_ok_i | input | 1 | Cache request accepted |
| send_fail_i | input | 1 | Cache request refused |
| retry_ok_i | input | 1 | Retried request accepted |
| fault_i | input | 1 | Fetch fault raised |
| quiesce_i | input | 1 | Quiesce instruction fetched |
| status_o | output | 3 | Current status code |
| pc_load_o | output | 1 | New PC loaded this cycle |
| pc_o | output | AW | Fetch PC |
| npc_o | output | AW | Next fetch PC |
| stage_active_o | output | 1 | Thread keeps fetch stage busy |
| stray_cnt_o | output | CNT_W | Count of discarded responses |

## Verification
The hardest case to reach is a matching response that lands in WAIT_RESP while a stall flag is still set. The stall has to arrive after the request is accepted, because a stall present earlier would have sent the thread to BLOCKED before it ever reached WAIT_RESP. A directed sequence therefore sends a request, pulses a decode block while the miss is still outstanding, and only then returns the response. Random traffic from a fixed seed drives the same paths, along with stacked squashes and stray responses, and every cycle is compared against a bench model built from the requirements.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SQUASH  = 3'd1,
    ST_BLOCK   = 3'd2,
    ST_WRESP   = 3'd3,
    ST_WRETRY  = 3'd4,
    ST_ACC     = 3'd5,
    ST_TRAP    = 3'd6,
    ST_QUIESCE = 3'd7
  } fetch_st_e;
endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags #(
  parameter int unsigned N_STAGES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_STAGES-1:0] blk_i,
  input  logic [N_STAGES-1:0] unblk_i,
  input  logic                ctx_switch_i,
  output logic [N_STAGES-1:0] flags_o,
  output logic                stalled_o
);
  logic [N_STAGES-1:0] flags_q, flags_d;

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    assign flags_d[g] = (flags_q[g] | blk_i[g]) & ~unblk_i[g];

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) flags_q[g] <= 1'b0;
      else         flags_q[g] <= flags_d[g];

    assert_unblk_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unblk_i[g] |-> (flags_q[g] && !blk_i[g]));
  end

  // stall view includes this cycle's pulses
  assign stalled_o = (|flags_d) | ctx_switch_i;
  assign flags_o   = flags_q;
endmodule

// File: rtl/fsc_status_fsm.sv
module fsc_status_fsm
  import fsc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stalled_i,
  input  logic             cmt_squash_i,
  input  logic             rob_squashing_i,
  input  logic             dec_squash_i,
  input  logic             resp_valid_i,
  input  logic             resp_match_i,
  input  logic             send_ok_i,
  input  logic             send_fail_i,
  input  logic             retry_ok_i,
  input  logic             fault_i,
  input  logic             quiesce_i,
  output fetch_st_e        state_o,
  output logic             take_cmt_o,
  output logic             take_dec_o,
  output logic [CNT_W-1:0] stray_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  fetch_st_e        st_q, st_d;
  logic             resp_take;
  logic [CNT_W-1:0] stray_q;

  always_comb begin
    st_d       = st_q;
    take_cmt_o = 1'b0;
    take_dec_o = 1'b0;
    resp_take  = 1'b0;
    if (cmt_squash_i) begin
      st_d       = ST_SQUASH;
      take_cmt_o = 1'b1;
    end else if (rob_squashing_i) begin
      st_d = ST_SQUASH;
    end else if (dec_squash_i && st_q != ST_SQUASH) begin
      st_d       = ST_SQUASH;
      take_dec_o = 1'b1;
    end else if (stalled_i && st_q != ST_WRESP) begin
      st_d = ST_BLOCK;
    end else begin
      unique case (st_q)
        ST_BLOCK, ST_SQUASH, ST_ACC: st_d = ST_RUN;
        ST_WRESP:
          if (resp_valid_i && resp_match_i) begin
            resp_take = 1'b1;
            st_d      = stalled_i ? ST_BLOCK : ST_ACC;
          end
        ST_WRETRY: if (retry_ok_i) st_d = ST_WRESP;
        ST_RUN:
          if      (fault_i)     st_d = ST_TRAP;
          else if (quiesce_i)   st_d = ST_QUIESCE;
          else if (send_fail_i) st_d = ST_WRETRY;
          else if (send_ok_i)   st_d = ST_WRESP;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stray_q <= '0;
    else if (resp_valid_i && !resp_take && stray_q != CNT_MAX) stray_q <= stray_q + 1'b1;

  assign state_o     = st_q;
  assign stray_cnt_o = stray_q;

  assert_cmt_squash_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmt_squash_i |=> st_q == ST_SQUASH);
  assert_rob_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rob_squashing_i |=> st_q == ST_SQUASH);
  assert_miss_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WRESP && !cmt_squash_i && !rob_squashing_i && !dec_squash_i && !resp_valid_i)
    |=> st_q == ST_WRESP);
  assert_trap_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TRAP && !cmt_squash_i && !rob_squashing_i && !dec_squash_i && !stalled_i)
    |=> st_q == ST_TRAP);
  assert_stray_mono_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_i |=> $stable(stray_q));
endmodule

// File: rtl/fsc_pc_load.sv
module fsc_pc_load #(
  parameter int unsigned AW         = 32,
  parameter int unsigned INST_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_cmt_i,
  input  logic [AW-1:0] cmt_target_i,
  input  logic          take_dec_i,
  input  logic [AW-1:0] dec_target_i,
  output logic          load_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] npc_o
);
  localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

  logic [AW-1:0] tgt;
  assign tgt = take_cmt_i ? cmt_target_i : dec_target_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      load_o <= 1'b0;
      pc_o   <= '0;
      npc_o  <= STEP;
    end else begin
      load_o <= take_cmt_i | take_dec_i;
      if (take_cmt_i || take_dec_i) begin
        pc_o  <= tgt;
        npc_o <= tgt + STEP;
      end
    end

  assert_pc_target_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_cmt_i |=> (load_o && pc_o == $past(cmt_target_i)));
  assert_pc_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_cmt_i && !take_dec_i) |=> ($stable(pc_o) && !load_o));
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
  import fsc_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned INST_BYTES = 4,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned N_STAGES   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                thread_active_i,
  input  logic [N_STAGES-1:0] blk_i,
  input  logic [N_STAGES-1:0] unblk_i,
  input  logic                ctx_switch_i,
  input  logic                cmt_squash_i,
  input  logic [AW-1:0]       cmt_target_i,
  input  logic                rob_squashing_i,
  input  logic                dec_squash_i,
  input  logic [AW-1:0]       dec_target_i,
  input  logic                resp_valid_i,
  input  logic                resp_match_i,
  input  logic                send_ok_i,
  input  logic                send_fail_i,
  input  logic                retry_ok_i,
  input  logic                fault_i,
  input  logic                quiesce_i,
  output logic [2:0]          status_o,
  output logic                pc_load_o,
  output logic [AW-1:0]       pc_o,
  output logic [AW-1:0]       npc_o,
  output logic                stage_active_o,
  output logic [CNT_W-1:0]    stray_cnt_o
);
  logic                stalled, take_cmt, take_dec;
  logic [N_STAGES-1:0] flags;
  fetch_st_e           st;

  fsc_stall_flags #(.N_STAGES(N_STAGES)) u_flags (
    .clk_i, .rst_ni, .blk_i, .unblk_i, .ctx_switch_i,
    .flags_o(flags), .stalled_o(stalled)
  );

  fsc_status_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .stalled_i(stalled), .cmt_squash_i, .rob_squashing_i,
    .dec_squash_i, .resp_valid_i, .resp_match_i, .send_ok_i, .send_fail_i,
    .retry_ok_i, .fault_i, .quiesce_i, .state_o(st), .take_cmt_o(take_cmt),
    .take_dec_o(take_dec), .stray_cnt_o
  );

  fsc_pc_load #(.AW(AW), .INST_BYTES(INST_BYTES)) u_pc (
    .clk_i, .rst_ni, .take_cmt_i(take_cmt), .cmt_target_i,
    .take_dec_i(take_dec), .dec_target_i, .load_o(pc_load_o), .pc_o, .npc_o
  );

  assign status_o       = st;
  assign stage_active_o = thread_active_i &&
                          (st == ST_RUN || st == ST_SQUASH || st == ST_ACC);

  assert_blocked_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flags && !ctx_switch_i && !cmt_squash_i && !rob_squashing_i && !dec_squash_i
     && st != ST_WRESP && unblk_i == '0) |=> status_o == 3'd2);
  assert_active_gate_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_active_o |-> thread_active_i);
endmodule

// File: tb/tb_fetch_status_ctrl.sv
`timescale 1ns/1ps
module tb_fetch_status_ctrl;
  localparam int AW = 32, IB = 4, CW = 8, NS = 4;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic          thr_act = 1;
  logic [NS-1:0] blk = '0, unblk = '0;
  logic          ctx = 0, cmt = 0, rob = 0, dec = 0;
  logic [AW-1:0] cmt_t = '0, dec_t = '0;
  logic          rv = 0, rm = 0, s_ok = 0, s_fail = 0, r_ok = 0, flt = 0, qsc = 0;
  logic [2:0]    status;
  logic          pc_load, active;
  logic [AW-1:0] pc, npc;
  logic [CW-1:0] stray;

  fetch_status_ctrl #(.AW(AW), .INST_BYTES(IB), .CNT_W(CW), .N_STAGES(NS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .thread_active_i(thr_act), .blk_i(blk), .unblk_i(unblk),
    .ctx_switch_i(ctx), .cmt_squash_i(cmt), .cmt_target_i(cmt_t), .rob_squashing_i(rob),
    .dec_squash_i(dec), .dec_target_i(dec_t), .resp_valid_i(rv), .resp_match_i(rm),
    .send_ok_i(s_ok), .send_fail_i(s_fail), .retry_ok_i(r_ok), .fault_i(flt),
    .quiesce_i(qsc), .status_o(status), .pc_load_o(pc_load), .pc_o(pc), .npc_o(npc),
    .stage_active_o(active), .stray_cnt_o(stray)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model, built from the requirements
  int            m_st = 0;
  logic [NS-1:0] m_fl = '0;
  logic [AW-1:0] m_pc = '0, m_npc = AW'(IB);
  logic          m_ld = 0;
  int            m_stray = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [NS-1:0] fn;
    bit st_d, taken;
    int nx;
    fn = (m_fl | blk) & ~unblk;
    st_d = (|fn) | ctx;
    nx = m_st; taken = 0; m_ld = 0;
    if (cmt) begin nx = 1; m_ld = 1; m_pc = cmt_t; end
    else if (rob) nx = 1;
    else if (dec && m_st != 1) begin nx = 1; m_ld = 1; m_pc = dec_t; end
    else if (st_d && m_st != 3) nx = 2;
    else case (m_st)
      1, 2, 5: nx = 0;
      3: if (rv && rm) begin taken = 1; nx = st_d ? 2 : 5; end
      4: if (r_ok) nx = 3;
      0: if (flt) nx = 6; else if (qsc) nx = 7; else if (s_fail) nx = 4; else if (s_ok) nx = 3;
      default: ;
    endcase
    if (m_ld) m_npc = m_pc + AW'(IB);
    if (rv && !taken && m_stray < 255) m_stray++;
    m_fl = fn;
    m_st = nx;
  endtask

  task automatic compare(input string tag);
    bit m_act;
    m_act = thr_act && (m_st == 0 || m_st == 1 || m_st == 5);
    chk(status == 3'(m_st), {tag, " status"}, status, m_st);
    chk(pc_load == m_ld && pc == m_pc && npc == m_npc, {tag, " pc"}, pc, m_pc);
    chk(active == m_act && stray == CW'(m_stray), {tag, " active/stray"},
        {active, stray}, {m_act, CW'(m_stray)});
  endtask

  task automatic clear_in();
    blk = '0; unblk = '0; ctx = 0; cmt = 0; rob = 0; dec = 0;
    rv = 0; rm = 0; s_ok = 0; s_fail = 0; r_ok = 0; flt = 0; qsc = 0;
  endtask

  // inputs are set before the call, at a negedge
  task automatic tick(input string tag);
    @(posedge clk); model_step();
    @(negedge clk); compare(tag); clear_in();
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1 reset");
    chk(status == 0 && npc == AW'(IB) && stray == 0, "R1", status, 0);

    s_ok = 1; tick("R11 send_ok");
    chk(status == 3 && !active, "R11/R13 wait resp", status, 3);
    blk[0] = 1; tick("R7");
    chk(status == 3, "R7 stall does not pre-empt miss", status, 3);
    rv = 1; rm = 1; tick("R9");
    chk(status == 2, "R9 response while stalled", status, 2);
    rv = 1; tick("R10");
    chk(status == 2 && stray == 1, "R10 stray counted", stray, 1);
    unblk[0] = 1; tick("R2");
    chk(status == 0, "R2/R8 unblock returns run", status, 0);
    ctx = 1; tick("R3");
    chk(status == 2, "R3 context switch stalls", status, 2);
    tick("R8"); chk(status == 0, "R8 blocked to run", status, 0);
    s_fail = 1; tick("R11");
    chk(status == 4, "R11 send fail", status, 4);
    r_ok = 1; tick("R11");
    chk(status == 3, "R11 retry ok", status, 3);
    rv = 1; rm = 0; tick("R10");
    chk(status == 3 && stray == 2, "R10 mismatch dropped", stray, 2);
    rv = 1; rm = 1; tick("R9");
    chk(status == 5 && active, "R9/R13 access done", status, 5);
    tick("R9"); chk(status == 0, "R9 done to run", status, 0);
    s_ok = 1; tick("R4 pre");
    cmt = 1; cmt_t = 32'h1000; dec = 1; dec_t = 32'h2000; blk[1] = 1; tick("R4");
    chk(status == 1 && pc == 32'h1000 && pc_load, "R4 commit squash wins", pc, 32'h1000);
    chk(npc == 32'h1004, "R14 next pc", npc, 32'h1004);
    tick("R2"); chk(status == 2, "R2 rename flag blocks", status, 2);
    unblk[1] = 1; tick("R2"); chk(status == 0, "R2 clear", status, 0);
    cmt = 1; cmt_t = 32'h1100; tick("R5 pre");
    rob = 1; tick("R5"); chk(status == 1, "R5 rob hold", status, 1);
    rob = 1; tick("R5"); chk(status == 1, "R5 rob hold 2", status, 1);
    dec = 1; dec_t = 32'h2200; tick("R6");
    chk(status == 0 && pc == 32'h1100 && !pc_load, "R6 decode squash ignored", pc, 32'h1100);
    dec = 1; dec_t = 32'h3000; tick("R6");
    chk(status == 1 && pc == 32'h3000 && npc == 32'h3004, "R6/R14 decode squash", pc, 32'h3000);
    tick("R8"); chk(status == 0, "R8 squash to run", status, 0);
    flt = 1; qsc = 1; tick("R12"); chk(status == 6, "R12 fault first", status, 6);
    tick("R12"); chk(status == 6, "R12 trap holds", status, 6);
    cmt = 1; cmt_t = 32'h40; tick("R4"); tick("R8");
    qsc = 1; tick("R12"); chk(status == 7, "R12 quiesce", status, 7);
    tick("R12"); chk(status == 7, "R12 quiesce holds", status, 7);
    thr_act = 0; cmt = 1; cmt_t = 32'h80; tick("R13");
    chk(!active, "R13 inactive thread", active, 0);
    thr_act = 1;

    for (int i = 0; i < 4000; i++) begin
      for (int s = 0; s < NS; s++) begin
        if (m_fl[s]) unblk[s] = ($urandom % 100) < 25;
        else         blk[s]   = ($urandom % 100) < 4;
      end
      ctx    = ($urandom % 100) < 3;
      cmt    = ($urandom % 100) < 4;
      cmt_t  = $urandom & ~32'h3;
      rob    = ($urandom % 100) < 4;
      dec    = ($urandom % 100) < 5;
      dec_t  = $urandom & ~32'h3;
      rv     = ($urandom % 100) < 25;
      rm     = ($urandom % 100) < 70;
      s_ok   = ($urandom % 100) < 30;
      s_fail = ($urandom % 100) < 10;
      r_ok   = ($urandom % 100) < 30;
      flt    = ($urandom % 100) < 3;
      qsc    = ($urandom % 100) < 3;
      if (($urandom % 100) < 2) thr_act = ~thr_act;
      tick("random R2..R14");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule